// File: doc/BRIEF.md
# Isochronous Receive Packet Dispatcher

This block sits between the receive FIFO that a link layer fills with isochronous packets and the memory bus that reaches host buffers. It reads the first word of each packet as a header and picks out the length, channel and tag fields. It then compares the channel and tag against the settings of a set of receive contexts. A packet accepted by a context costs one descriptor read and then one word write per body word into host memory. A packet no context wants is emptied from the FIFO without touching the bus.

There are `N_SC` single-channel contexts, numbered 0 to `N_SC-1`. Each one listens to exactly one channel. One more context, numbered `N_SC`, takes any channel whose bit is set in a 64-bit mask. The single-channel contexts win over the mask context, and among themselves the lowest number wins. The descriptor for context k is one word at `desc_base + 4*k`, and it holds the byte address of the destination buffer. Each accepted packet ends with a one-cycle done pulse for its context.

Top module: `iso_rx_dispatch`

## Requirements
- R1: While idle, the block pops the FIFO in the same cycle that `fifo_empty` is low, and it takes that word as a header. It never pops an empty FIFO.
- R2: Header fields are length in bits 31:16, tag in bits 15:14 and channel in bits 13:8. A context accepts a packet only if its enable bit is set, its channel test passes, and bit `tag` of its 4-bit tag mask is 1.
- R3: When several single-channel contexts accept a packet, the lowest-numbered one gets it.
- R4: Context `N_SC` accepts a channel c when bit c of `mc_chan_mask` is set, and it is considered only when no single-channel context accepts the packet.
- R5: On acceptance the block raises `mem_req`. It issues the descriptor read (`mem_rd`, address `desc_base + 4*k`) only in a cycle where `mem_gnt` is high, and it issues no bus traffic while the grant is withheld.
- R6: The body holds ceil(length/4) words. They are written in FIFO order to consecutive word addresses, starting at the address returned by the descriptor read.
- R7: A packet that no context accepts has all of its body words popped, with `mem_req`, `mem_rd` and `mem_wr` held low.
- R8: After the last body word of an accepted packet, `pkt_done` pulses for one cycle with only the bit of the chosen context set.
- R9: A packet of length 0 consumes only its header word. If it is accepted, it still gets its descriptor read and done pulse, with no data writes.
- R10: While reset is asserted and on leaving reset, `fifo_rd`, `mem_req`, `mem_rd`, `mem_wr` and `pkt_done` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fifo_empty | input | 1 | Receive FIFO holds no word |
| fifo_rdata | input | 32 | Word at the FIFO head (show-ahead) |
| fifo_rd | output | 1 | Pop the FIFO head this cycle |
| ctx_en | input | N_SC+1 | Per-context enable; top bit is the mask context |
| ctx_chan | input | N_SC*6 | Channel of each single-channel context |
| ctx_tag_mask | input | (N_SC+1)*4 | Accepted tags per context, bit t accepts tag t |
| mc_chan_mask | input | 64 | Channels accepted by context N_SC |
| desc_base | input | AW | Base of the per-context descriptor words |
| mem_req | output | 1 | Bus ownership request |
| mem_gnt | input | 1 | Bus granted |
| mem_rd | output | 1 | Descriptor read strobe |
| mem_wr | output | 1 | Data write strobe |
| mem_addr | output | AW | Byte address for read or write |
| mem_wdata | output | DW | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DW | Read data (descriptor) |
| pkt_done | output | N_SC+1 | One-cycle completion pulse per context |

## Verification
Packets are sent on channels chosen to separate the cases: a channel owned by one single context, a channel shared by two single contexts and also present in the mask, a channel found only in the mask, and a channel whose only single owner is disabled. Tag values that the owner's mask rejects show that tag filtering really drops a packet. Lengths 0, 1, 4 and 10 bytes test the rounding to whole words. A withheld grant shows that no descriptor read or write leaks before ownership, and two packets queued back to back check that a dropped packet leaves the next header aligned.

// File: rtl/iso_rx_pkg.sv
// Shared types and helpers for the isochronous receive dispatcher.
// Assumes 32-bit FIFO words carrying the header layout documented in the brief.
package iso_rx_pkg;

    localparam int CH_W   = 6;
    localparam int N_CHAN = 64;
    localparam int TAG_W  = 2;
    localparam int TAGM_W = 4;

    typedef enum logic [2:0] {
        S_IDLE,
        S_MATCH,
        S_REQ,
        S_DESC,
        S_MOVE,
        S_DRAIN,
        S_DONE
    } seq_state_t;

    typedef struct packed {
        logic [15:0]      len;
        logic [TAG_W-1:0] tag;
        logic [CH_W-1:0]  chan;
    } hdr_fields_t;

    // Number of 32-bit words needed for a byte length.
    function automatic logic [15:0] body_words(input logic [15:0] len);
        logic [16:0] sum;
        sum = {1'b0, len} + 17'd3;
        return sum[17-1:2];
    endfunction

endpackage

// File: rtl/iso_rx_matcher.sv
// Context matcher: compares a header's channel and tag with every context.
// Single-channel contexts 0..N_SC-1 win over the mask context N_SC; lowest index wins.
// Purely combinational; assumes stable header fields while it is sampled.
module iso_rx_matcher
    import iso_rx_pkg::*;
#(
    parameter int N_SC = 4,
    localparam int IW  = $clog2(N_SC + 1)
) (
    input  logic [CH_W-1:0]         chan,
    input  logic [TAG_W-1:0]        tag,
    input  logic [N_SC:0]           ctx_en,
    input  logic [N_SC*CH_W-1:0]    ctx_chan,
    input  logic [(N_SC+1)*TAGM_W-1:0] ctx_tag_mask,
    input  logic [N_CHAN-1:0]       mc_chan_mask,
    output logic                    hit,
    output logic [IW-1:0]           sel
);

    logic [N_SC-1:0] sc_hit;
    logic            mc_hit;

    // One comparator per single-channel context.
    for (genvar i = 0; i < N_SC; i++) begin : g_sc
        assign sc_hit[i] = ctx_en[i]
                         && (ctx_chan[i*CH_W +: CH_W] == chan)
                         && ctx_tag_mask[i*TAGM_W + int'(tag)];
    end

    assign mc_hit = ctx_en[N_SC] && mc_chan_mask[chan]
                  && ctx_tag_mask[N_SC*TAGM_W + int'(tag)];

    // Priority pick: lowest single context, then the mask context.
    always_comb begin
        hit = 1'b0;
        sel = '0;
        for (int i = N_SC - 1; i >= 0; i--) begin
            if (sc_hit[i]) begin
                hit = 1'b1;
                sel = IW'(i);
            end
        end
        if (!hit && mc_hit) begin
            hit = 1'b1;
            sel = IW'(N_SC);
        end
    end

endmodule

// File: rtl/iso_rx_seq.sv
// Packet sequencer: pops headers, waits one cycle for the match result, then
// either fetches a descriptor and copies the body to memory, or drains the body.
// Assumes a show-ahead FIFO and a grant that stays high while mem_req is held.
module iso_rx_seq
    import iso_rx_pkg::*;
#(
    parameter int N_SC = 4,
    parameter int AW   = 32,
    parameter int DW   = 32,
    localparam int IW  = $clog2(N_SC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_empty,
    input  logic [DW-1:0]    fifo_rdata,
    output logic             fifo_rd,
    output hdr_fields_t      hdr,
    input  logic             hit,
    input  logic [IW-1:0]    sel,
    input  logic [AW-1:0]    desc_base,
    output logic             mem_req,
    input  logic             mem_gnt,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic             mem_rvalid,
    input  logic [DW-1:0]    mem_rdata,
    output logic [N_SC:0]    pkt_done
);

    seq_state_t    state;
    hdr_fields_t   hdr_q;
    logic [IW-1:0] ctx_q;
    logic [15:0]   words_left;
    logic [AW-1:0] wr_addr;
    logic [15:0]   nwords;

    assign hdr    = hdr_q;
    assign nwords = body_words(hdr_q.len);

    // Strobes and bus outputs decoded from the current state.
    always_comb begin
        fifo_rd   = 1'b0;
        mem_req   = 1'b0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = wr_addr;
        mem_wdata = fifo_rdata;
        case (state)
            S_IDLE:  fifo_rd = !fifo_empty;
            S_REQ: begin
                mem_req  = 1'b1;
                mem_rd   = mem_gnt;
                mem_addr = desc_base + (AW'(ctx_q) << 2);
            end
            S_DESC:  mem_req = 1'b1;
            S_MOVE: begin
                mem_req = 1'b1;
                fifo_rd = !fifo_empty;
                mem_wr  = !fifo_empty;
            end
            S_DRAIN: fifo_rd = !fifo_empty;
            default: ;
        endcase
    end

    // State, header, context and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            hdr_q      <= '0;
            ctx_q      <= '0;
            words_left <= '0;
            wr_addr    <= '0;
        end else begin
            case (state)
                S_IDLE: if (!fifo_empty) begin
                    hdr_q.len  <= fifo_rdata[31:16];
                    hdr_q.tag  <= fifo_rdata[15:14];
                    hdr_q.chan <= fifo_rdata[13:8];
                    state      <= S_MATCH;
                end
                S_MATCH: begin
                    words_left <= nwords;
                    ctx_q      <= sel;
                    if (hit)              state <= S_REQ;
                    else if (nwords == 0) state <= S_IDLE;
                    else                  state <= S_DRAIN;
                end
                S_REQ: if (mem_gnt) state <= S_DESC;
                S_DESC: if (mem_rvalid) begin
                    wr_addr <= AW'(mem_rdata);
                    state   <= (words_left == 0) ? S_DONE : S_MOVE;
                end
                S_MOVE: if (!fifo_empty) begin
                    wr_addr    <= wr_addr + AW'(4);
                    words_left <= words_left - 16'd1;
                    if (words_left == 16'd1) state <= S_DONE;
                end
                S_DRAIN: if (!fifo_empty) begin
                    words_left <= words_left - 16'd1;
                    if (words_left == 16'd1) state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // One done line per context, pulsed in the completion state.
    for (genvar k = 0; k <= N_SC; k++) begin : g_done
        assign pkt_done[k] = (state == S_DONE) && (ctx_q == IW'(k));
    end

    p_pop_nonempty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> !fifo_empty);

    p_desc_after_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (mem_gnt && mem_req));

    p_drop_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DRAIN) |-> (!mem_req && !mem_rd && !mem_wr));

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pkt_done));

    p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && $past(mem_wr)) |-> (mem_addr == $past(mem_addr) + AW'(4)));

endmodule

// File: rtl/iso_rx_dispatch.sv
// Top of the isochronous receive dispatcher: header sequencer plus context matcher.
// Assumes one FIFO word per cycle at most and a single memory bus master port.
module iso_rx_dispatch
    import iso_rx_pkg::*;
#(
    parameter int N_SC = 4,
    parameter int AW   = 32,
    parameter int DW   = 32,
    localparam int IW  = $clog2(N_SC + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        fifo_empty,
    input  logic [DW-1:0]               fifo_rdata,
    output logic                        fifo_rd,
    input  logic [N_SC:0]               ctx_en,
    input  logic [N_SC*CH_W-1:0]        ctx_chan,
    input  logic [(N_SC+1)*TAGM_W-1:0]  ctx_tag_mask,
    input  logic [N_CHAN-1:0]           mc_chan_mask,
    input  logic [AW-1:0]               desc_base,
    output logic                        mem_req,
    input  logic                        mem_gnt,
    output logic                        mem_rd,
    output logic                        mem_wr,
    output logic [AW-1:0]               mem_addr,
    output logic [DW-1:0]               mem_wdata,
    input  logic                        mem_rvalid,
    input  logic [DW-1:0]               mem_rdata,
    output logic [N_SC:0]               pkt_done
);

    hdr_fields_t   hdr;
    logic          hit;
    logic [IW-1:0] sel;

    iso_rx_matcher #(.N_SC(N_SC)) u_match (
        .chan         (hdr.chan),
        .tag          (hdr.tag),
        .ctx_en       (ctx_en),
        .ctx_chan     (ctx_chan),
        .ctx_tag_mask (ctx_tag_mask),
        .mc_chan_mask (mc_chan_mask),
        .hit          (hit),
        .sel          (sel)
    );

    iso_rx_seq #(.N_SC(N_SC), .AW(AW), .DW(DW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_empty (fifo_empty),
        .fifo_rdata (fifo_rdata),
        .fifo_rd    (fifo_rd),
        .hdr        (hdr),
        .hit        (hit),
        .sel        (sel),
        .desc_base  (desc_base),
        .mem_req    (mem_req),
        .mem_gnt    (mem_gnt),
        .mem_rd     (mem_rd),
        .mem_wr     (mem_wr),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .pkt_done   (pkt_done)
    );

endmodule

// File: tb/iso_rx_dispatch_tb.sv
module iso_rx_dispatch_tb;

    localparam int N_SC = 4;
    localparam logic [31:0] DBASE = 32'h0000_1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic                fifo_empty, fifo_rd;
    logic [31:0]         fifo_rdata;
    logic [N_SC:0]       ctx_en;
    logic [N_SC*6-1:0]   ctx_chan;
    logic [(N_SC+1)*4-1:0] ctx_tag_mask;
    logic [63:0]         mc_chan_mask;
    logic                mem_req, mem_gnt, mem_rd, mem_wr, mem_rvalid;
    logic [31:0]         mem_addr, mem_wdata, mem_rdata;
    logic [N_SC:0]       pkt_done;

    iso_rx_dispatch #(.N_SC(N_SC)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .fifo_empty(fifo_empty), .fifo_rdata(fifo_rdata), .fifo_rd(fifo_rd),
        .ctx_en(ctx_en), .ctx_chan(ctx_chan), .ctx_tag_mask(ctx_tag_mask),
        .mc_chan_mask(mc_chan_mask), .desc_base(DBASE),
        .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .pkt_done(pkt_done)
    );

    int checks = 0;
    int errors = 0;

    // FIFO model (show-ahead)
    logic [31:0] fmem [0:255];
    int fhead = 0;
    int ftail = 0;
    assign fifo_empty = (fhead == ftail);
    assign fifo_rdata = fmem[fhead[7:0]];
    always @(posedge clk) if (fifo_rd) fhead <= fhead + 1;

    // Memory model: grant one cycle after request, read data two cycles after mem_rd
    logic gnt_hold = 1'b0;
    logic rd_d1 = 1'b0;
    logic [31:0] rd_a1 = '0;
    logic [31:0] wa [0:255];
    logic [31:0] wd [0:255];
    int wn = 0;
    int rd_cnt = 0;
    logic [31:0] last_rd_addr = '0;
    int done_cnt = 0;
    logic [N_SC:0] last_done = '0;

    always @(posedge clk) begin
        mem_gnt    <= rst_n && mem_req && !gnt_hold;
        rd_d1      <= mem_rd;
        rd_a1      <= mem_addr;
        mem_rvalid <= rd_d1;
        mem_rdata  <= 32'h8000_0000 + ((rd_a1 - DBASE) << 10);
        if (mem_rd) begin rd_cnt <= rd_cnt + 1; last_rd_addr <= mem_addr; end
        if (mem_wr) begin wa[wn[7:0]] <= mem_addr; wd[wn[7:0]] <= mem_wdata; wn <= wn + 1; end
        if (|pkt_done) begin done_cnt <= done_cnt + 1; last_done <= pkt_done; end
    end
    initial begin mem_gnt = 0; mem_rvalid = 0; mem_rdata = '0; end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push_pkt(input int ch, input int tag, input int len, input logic [31:0] seed);
        int nw;
        nw = (len + 3) / 4;
        fmem[ftail[7:0]] = {len[15:0], tag[1:0], ch[5:0], 4'hA, 4'h0};
        ftail = ftail + 1;
        for (int i = 0; i < nw; i++) begin
            fmem[ftail[7:0]] = seed + i;
            ftail = ftail + 1;
        end
    endtask

    task automatic t_accept(input string req, input int ch, input int tag, input int len, input int ctx);
        int w0, d0, r0, nw;
        logic [31:0] seed;
        w0 = wn; d0 = done_cnt; r0 = rd_cnt; nw = (len + 3) / 4;
        seed = 32'hA000_0000 + (ch << 12) + (len << 4);
        push_pkt(ch, tag, len, seed);
        repeat (40) @(negedge clk);
        chk(wn - w0 == nw, req, wn - w0, nw);
        chk(rd_cnt - r0 == 1 && last_rd_addr == DBASE + 4 * ctx, {req, " R5 desc"}, last_rd_addr, DBASE + 4 * ctx);
        for (int i = 0; i < nw; i++) begin
            chk(wa[(w0 + i) % 256] == 32'h8000_0000 + ctx * 32'h1000 + 4 * i, {req, " R6 addr"},
                wa[(w0 + i) % 256], 32'h8000_0000 + ctx * 32'h1000 + 4 * i);
            chk(wd[(w0 + i) % 256] == seed + i, {req, " R6 data"}, wd[(w0 + i) % 256], seed + i);
        end
        chk(done_cnt - d0 == 1 && last_done == (1 << ctx), {req, " R8 done"}, last_done, 1 << ctx);
        chk(fifo_empty, {req, " R1 drained"}, fhead, ftail);
    endtask

    task automatic t_drop(input string req, input int ch, input int tag, input int len);
        int w0, d0, r0;
        w0 = wn; d0 = done_cnt; r0 = rd_cnt;
        push_pkt(ch, tag, len, 32'h5500_0000);
        repeat (30) @(negedge clk);
        chk(wn == w0 && rd_cnt == r0, {req, " R7 no bus"}, wn - w0, 0);
        chk(done_cnt == d0, {req, " R7 no done"}, done_cnt - d0, 0);
        chk(fifo_empty, {req, " R7 drained"}, fhead, ftail);
    endtask

    task automatic t_reset;
        #1;
        chk(!fifo_rd && !mem_req && !mem_rd && !mem_wr && pkt_done == 0, "R10 in reset",
            {fifo_rd, mem_req, mem_rd, mem_wr}, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(!fifo_rd && !mem_req && !mem_wr && pkt_done == 0, "R10 after reset",
            {fifo_rd, mem_req, mem_wr}, 0);
    endtask

    task automatic t_grant_hold;
        int w0, r0;
        w0 = wn; r0 = rd_cnt;
        gnt_hold = 1'b1;
        push_pkt(9, 0, 8, 32'h7700_0000);
        #1;
        chk(fifo_rd == 1'b1, "R1 pop at once", fifo_rd, 1);
        repeat (20) @(negedge clk);
        chk(mem_req == 1'b1, "R5 request held", mem_req, 1);
        chk(rd_cnt == r0 && wn == w0, "R5 no traffic without grant", rd_cnt - r0, 0);
        chk(ftail - fhead == 2, "R5 body waits", ftail - fhead, 2);
        gnt_hold = 1'b0;
        repeat (30) @(negedge clk);
        chk(wn - w0 == 2 && wa[w0 % 256] == 32'h8000_1000, "R5 after grant", wa[w0 % 256], 32'h8000_1000);
        chk(last_done == 5'b00010, "R8 after grant", last_done, 5'b00010);
    endtask

    task automatic t_zero_len;
        int w0, d0;
        w0 = wn; d0 = done_cnt;
        push_pkt(5, 1, 0, 0);
        repeat (30) @(negedge clk);
        chk(wn == w0, "R9 no writes", wn - w0, 0);
        chk(done_cnt - d0 == 1 && last_done == 5'b00001, "R9 done", last_done, 1);
        chk(fifo_empty, "R9 header only", fhead, ftail);
        d0 = done_cnt;
        push_pkt(40, 0, 0, 0);
        repeat (20) @(negedge clk);
        chk(done_cnt == d0 && fifo_empty, "R9 dropped empty", done_cnt - d0, 0);
    endtask

    task automatic t_back_to_back;
        int w0;
        w0 = wn;
        push_pkt(5, 2, 12, 32'h3300_0000);
        push_pkt(5, 1, 8, 32'h4400_0000);
        repeat (50) @(negedge clk);
        chk(wn - w0 == 2, "R7 drop then accept", wn - w0, 2);
        chk(wd[w0 % 256] == 32'h4400_0000, "R1 header realigned", wd[w0 % 256], 32'h4400_0000);
        chk(last_done == 5'b00001, "R8 second packet", last_done, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // ctx0: ch5 tag1 only; ctx1, ctx2: ch9 any tag; ctx3: disabled ch12; mask ctx: ch9,12,20
        ctx_en       = 5'b10111;
        ctx_chan     = {6'd12, 6'd9, 6'd9, 6'd5};
        ctx_tag_mask = {4'hF, 4'hF, 4'hF, 4'hF, 4'b0010};
        mc_chan_mask = (64'd1 << 9) | (64'd1 << 12) | (64'd1 << 20);
        repeat (3) @(negedge clk);
        t_reset();
        t_accept("R2 ch5 tag1", 5, 1, 10, 0);
        t_drop("R2 tag rejected", 5, 0, 10);
        t_accept("R3 shared ch9", 9, 3, 16, 1);
        t_accept("R4 mask ch20", 20, 2, 4, 4);
        t_accept("R4 disabled single ch12", 12, 0, 7, 4);
        t_accept("R6 len1", 5, 1, 1, 0);
        t_drop("R7 unknown ch33", 33, 1, 20);
        t_grant_hold();
        t_zero_len();
        t_back_to_back();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule